// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block sits on the system bus between a CPU data port and the memory system. It tracks a single reservation for atomic word accesses. A load-reserved access records the address region it touches. A later store-conditional is either passed to the bus or ended inside the block. While the reservation is held, the block watches ordinary stores from the CPU, stores from a DMA master and an external clear input. Any of these can cancel the reservation.

A store-conditional that still owns the reservation is forwarded to the bus. When the bus acknowledges that write, the CPU receives the status word 0. A store-conditional that has lost its reservation never reaches the bus. Instead the block raises its own acknowledge one cycle later and returns the status word 1. Other traffic passes through unchanged: read strobes, ordinary write strobes and responses that do not belong to a store-conditional.

Top module: `rsv_monitor`

## Requirements
- R1: After reset no reservation is held. A store-conditional issued before any load-reserved fails: the write strobe is not forwarded, and in the next cycle `cpu_ack_o` is 1 with `cpu_rdata_o` equal to 1.
- R2: A reservation covers an aligned region of 2^GRAN_LOG2 bytes (16 with defaults). Two addresses hit the same reservation when they are equal above bit GRAN_LOG2-1. The lower bits are ignored.
- R3: A read with `cpu_rsv_i` = 1 (load-reserved) takes a reservation on its region. The read strobe is forwarded unchanged on `bus_re_o`.
- R4: A load-reserved issued while a reservation is held replaces the held region with the new one. The reservation stays valid.
- R5: A store-conditional that hits the held region, with no clear and no DMA hit in the same cycle, is forwarded on `bus_we_o` in the same cycle. On the bus ACK that ends it, `cpu_rdata_o` is 0.
- R6: A store-conditional that misses the held region, or arrives with no reservation held, is not forwarded. The next cycle carries a local ACK with status 1, and any held reservation is dropped.
- R7: An ordinary CPU write (`cpu_rsv_i` = 0) into the held region drops the reservation. An ordinary write outside the region leaves it intact.
- R8: A DMA write (`dma_we_i`) into the held region drops the reservation. If the DMA write falls in the same cycle as a store-conditional, that store-conditional fails.
- R9: `clear_i` cancels a held reservation and wins over every other request in the same cycle. This covers a store-conditional, which then fails, and a load-reserved, which is then not registered.
- R10: Once a store-conditional has been forwarded, the reservation is released on the first cycle with `bus_ack_i` or `bus_err_i`. Until then `clear_i` has no effect, and a later store-conditional fails.
- R11: Outside the status cycle of a store-conditional, `cpu_ack_o`, `cpu_err_o` and `cpu_rdata_o` follow `bus_ack_i`, `bus_err_i` and `bus_rdata_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | External request to cancel the reservation |
| cpu_re_i | input | 1 | CPU read request pulse |
| cpu_we_i | input | 1 | CPU write request pulse |
| cpu_rsv_i | input | 1 | Marks the request as load-reserved (read) or store-conditional (write) |
| cpu_addr_i | input | AW | CPU byte address |
| dma_we_i | input | 1 | DMA write request pulse |
| dma_addr_i | input | AW | DMA byte address |
| bus_re_o | output | 1 | Read pulse forwarded to the bus |
| bus_we_o | output | 1 | Write pulse forwarded to the bus, suppressed for a failing store-conditional |
| bus_ack_i | input | 1 | Bus acknowledge |
| bus_err_i | input | 1 | Bus error |
| bus_rdata_i | input | DW | Bus read data |
| cpu_ack_o | output | 1 | Acknowledge returned to the CPU |
| cpu_err_o | output | 1 | Error returned to the CPU |
| cpu_rdata_o | output | DW | Read data or store-conditional status returned to the CPU |

## Verification
The assertions check these rules on every cycle:
- A write pulse never appears on the bus without a CPU write behind it.
- A suppressed store-conditional is always followed by a local ACK carrying status 1.
- A clear outside the in-flight state always leaves the monitor idle.
- The in-flight state always ends on the first ACK or ERR.
- That ending ACK carries status 0.

Other behaviour only shows up in the bench's scenarios, where a reference model is compared against the outputs on every clock. This covers the region arithmetic and which low address bits are ignored. It also covers a consecutive load-reserved replacing the region, and the order of ordinary CPU and DMA stores against a store-conditional.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    RSV_IDLE    = 2'b00,
    RSV_HELD    = 2'b10,
    RSV_SC_WAIT = 2'b11
  } rsv_state_e;

  localparam int unsigned RSV_PORT_CPU = 0;
  localparam int unsigned RSV_PORT_DMA = 1;
  localparam int unsigned RSV_NPORT    = 2;
endpackage

// File: rtl/rsv_tag_match.sv
module rsv_tag_match #(
  parameter int unsigned AW        = 32,
  parameter int unsigned GRAN_LOG2 = 4,
  parameter int unsigned NPORT     = 2,
  localparam int unsigned TW       = AW - GRAN_LOG2
) (
  input  logic [TW-1:0]            tag_i,
  input  logic [NPORT-1:0][AW-1:0] addr_i,
  output logic [NPORT-1:0]         hit_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign hit_o[p] = (addr_i[p][AW-1:GRAN_LOG2] == tag_i);
  end
endmodule

// File: rtl/rsv_fsm.sv
module rsv_fsm
  import rsv_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned GRAN_LOG2 = 4,
  localparam int unsigned TW       = AW - GRAN_LOG2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 cpu_re_i,
  input  logic                 cpu_we_i,
  input  logic                 cpu_rsv_i,
  input  logic [AW-1:0]        cpu_addr_i,
  input  logic                 dma_we_i,
  input  logic [RSV_NPORT-1:0] hit_i,
  input  logic                 bus_ack_i,
  input  logic                 bus_err_i,
  output logic [TW-1:0]        tag_o,
  output rsv_state_e           state_o,
  output logic                 sc_ok_o,
  output logic                 sc_fail_o
);
  rsv_state_e    state_q, state_d;
  logic [TW-1:0] tag_q, tag_d;

  logic lr, sc, cpu_st_hit, dma_st_hit, held;

  always_comb begin
    lr         = cpu_re_i & cpu_rsv_i;
    sc         = cpu_we_i & cpu_rsv_i;
    cpu_st_hit = cpu_we_i & ~cpu_rsv_i & hit_i[RSV_PORT_CPU];
    dma_st_hit = dma_we_i & hit_i[RSV_PORT_DMA];
    held       = (state_q == RSV_HELD);
    // any invalidation in the same cycle beats the store-conditional
    sc_ok_o    = sc & held & hit_i[RSV_PORT_CPU] & ~clear_i & ~dma_st_hit;
    sc_fail_o  = sc & ~sc_ok_o;
  end

  always_comb begin
    state_d = state_q;
    tag_d   = tag_q;
    unique case (state_q)
      RSV_IDLE: begin
        if (lr && !clear_i) begin
          state_d = RSV_HELD;
          tag_d   = cpu_addr_i[AW-1:GRAN_LOG2];
        end
      end
      RSV_HELD: begin
        if (clear_i) begin
          state_d = RSV_IDLE;
        end else if (sc) begin
          state_d = sc_ok_o ? RSV_SC_WAIT : RSV_IDLE;
        end else if (cpu_st_hit || dma_st_hit) begin
          state_d = RSV_IDLE;
        end else if (lr) begin
          tag_d = cpu_addr_i[AW-1:GRAN_LOG2];
        end
      end
      RSV_SC_WAIT: begin
        if (bus_ack_i || bus_err_i) state_d = RSV_IDLE;
      end
      default: state_d = RSV_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RSV_IDLE;
      tag_q   <= '0;
    end else begin
      state_q <= state_d;
      tag_q   <= tag_d;
    end
  end

  assign tag_o   = tag_q;
  assign state_o = state_q;
endmodule

// File: rtl/rsv_resp.sv
module rsv_resp
  import rsv_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_we_i,
  input  logic          sc_fail_i,
  input  rsv_state_e    state_i,
  input  logic          bus_ack_i,
  input  logic          bus_err_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          bus_we_o,
  output logic          cpu_ack_o,
  output logic          cpu_err_o,
  output logic [DW-1:0] cpu_rdata_o
);
  localparam logic [DW-1:0] STAT_OK   = '0;
  localparam logic [DW-1:0] STAT_FAIL = DW'(1);

  logic fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fail_q <= 1'b0;
    else         fail_q <= sc_fail_i;
  end

  assign bus_we_o  = cpu_we_i & ~sc_fail_i;
  assign cpu_ack_o = bus_ack_i | fail_q;
  assign cpu_err_o = bus_err_i;

  always_comb begin
    if (fail_q)                                    cpu_rdata_o = STAT_FAIL;
    else if (state_i == RSV_SC_WAIT && bus_ack_i)  cpu_rdata_o = STAT_OK;
    else                                           cpu_rdata_o = bus_rdata_i;
  end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned GRAN_LOG2 = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          cpu_re_i,
  input  logic          cpu_we_i,
  input  logic          cpu_rsv_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic          dma_we_i,
  input  logic [AW-1:0] dma_addr_i,
  output logic          bus_re_o,
  output logic          bus_we_o,
  input  logic          bus_ack_i,
  input  logic          bus_err_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          cpu_ack_o,
  output logic          cpu_err_o,
  output logic [DW-1:0] cpu_rdata_o
);
  localparam int unsigned TW = AW - GRAN_LOG2;

  logic [TW-1:0]                  tag_w;
  logic [RSV_NPORT-1:0][AW-1:0]   snoop_addr;
  logic [RSV_NPORT-1:0]           hit_w;
  rsv_state_e                     state_w;
  logic                           sc_ok_w, sc_fail_w;

  assign snoop_addr[RSV_PORT_CPU] = cpu_addr_i;
  assign snoop_addr[RSV_PORT_DMA] = dma_addr_i;
  assign bus_re_o = cpu_re_i;

  rsv_tag_match #(.AW(AW), .GRAN_LOG2(GRAN_LOG2), .NPORT(RSV_NPORT)) u_match (
    .tag_i (tag_w),
    .addr_i(snoop_addr),
    .hit_o (hit_w)
  );

  rsv_fsm #(.AW(AW), .GRAN_LOG2(GRAN_LOG2)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .cpu_re_i  (cpu_re_i),
    .cpu_we_i  (cpu_we_i),
    .cpu_rsv_i (cpu_rsv_i),
    .cpu_addr_i(cpu_addr_i),
    .dma_we_i  (dma_we_i),
    .hit_i     (hit_w),
    .bus_ack_i (bus_ack_i),
    .bus_err_i (bus_err_i),
    .tag_o     (tag_w),
    .state_o   (state_w),
    .sc_ok_o   (sc_ok_w),
    .sc_fail_o (sc_fail_w)
  );

  rsv_resp #(.DW(DW)) u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_we_i   (cpu_we_i),
    .sc_fail_i  (sc_fail_w),
    .state_i    (state_w),
    .bus_ack_i  (bus_ack_i),
    .bus_err_i  (bus_err_i),
    .bus_rdata_i(bus_rdata_i),
    .bus_we_o   (bus_we_o),
    .cpu_ack_o  (cpu_ack_o),
    .cpu_err_o  (cpu_err_o),
    .cpu_rdata_o(cpu_rdata_o)
  );
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk
  import rsv_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clear_i,
  input logic          cpu_we_i,
  input logic          cpu_rsv_i,
  input logic          bus_we_o,
  input logic          bus_ack_i,
  input logic          bus_err_i,
  input logic          cpu_ack_o,
  input logic [DW-1:0] cpu_rdata_o,
  input rsv_state_e    state_w
);
  // R6
  we_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> cpu_we_i);

  // R6
  sc_fail_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_rsv_i && !bus_we_o) |=> (cpu_ack_o && cpu_rdata_o == DW'(1)));

  // R9
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && state_w != RSV_SC_WAIT) |=> (state_w == RSV_IDLE));

  // R10
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == RSV_SC_WAIT && (bus_ack_i || bus_err_i)) |=> (state_w == RSV_IDLE));

  // R5
  sc_ok_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == RSV_SC_WAIT && bus_ack_i) |-> (cpu_ack_o && cpu_rdata_o == '0));
endmodule

bind rsv_monitor rsv_monitor_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clear_i    (clear_i),
  .cpu_we_i   (cpu_we_i),
  .cpu_rsv_i  (cpu_rsv_i),
  .bus_we_o   (bus_we_o),
  .bus_ack_i  (bus_ack_i),
  .bus_err_i  (bus_err_i),
  .cpu_ack_o  (cpu_ack_o),
  .cpu_rdata_o(cpu_rdata_o),
  .state_w    (state_w)
);

// File: tb/rsv_monitor_tb.sv
`timescale 1ns/1ps
module rsv_monitor_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int G  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear, re, we, rsv, dma_we, ack, err;
  logic [AW-1:0] addr, dma_addr;
  logic [DW-1:0] rdata;
  logic bus_re, bus_we, cpu_ack, cpu_err;
  logic [DW-1:0] cpu_rdata;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";
  bit done = 0;

  // reference model: 0 idle, 1 held, 2 store-conditional in flight
  int m_state = 0;
  longint unsigned m_tag = 0;
  bit m_fail = 0;

  always #2.5 clk = ~clk;

  rsv_monitor #(.AW(AW), .DW(DW), .GRAN_LOG2(G)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .cpu_re_i(re), .cpu_we_i(we), .cpu_rsv_i(rsv), .cpu_addr_i(addr),
    .dma_we_i(dma_we), .dma_addr_i(dma_addr),
    .bus_re_o(bus_re), .bus_we_o(bus_we),
    .bus_ack_i(ack), .bus_err_i(err), .bus_rdata_i(rdata),
    .cpu_ack_o(cpu_ack), .cpu_err_o(cpu_err), .cpu_rdata_o(cpu_rdata)
  );

  function automatic bit hits(logic [AW-1:0] a);
    return (longint'(a) >> G) == m_tag;
  endfunction

  task automatic check(string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare and advance the model away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        bit lr, sc, ok, dma_hit;
        longint unsigned e_rd;
        lr = re & rsv;
        sc = we & rsv;
        dma_hit = dma_we && hits(dma_addr);
        ok = sc && m_state == 1 && hits(addr) && !clear && !dma_hit;
        if (m_fail) e_rd = 1;
        else if (m_state == 2 && ack) e_rd = 0;
        else e_rd = rdata;
        check("bus_re", bus_re, re);
        check("bus_we", bus_we, we && !(sc && !ok));
        check("cpu_ack", cpu_ack, ack || m_fail);
        check("cpu_err", cpu_err, err);
        check("cpu_rdata", cpu_rdata, e_rd);
        m_fail = sc && !ok;
        case (m_state)
          0: if (lr && !clear) begin m_state = 1; m_tag = longint'(addr) >> G; end
          1: begin
            if (clear) m_state = 0;
            else if (sc) m_state = ok ? 2 : 0;
            else if ((we && !rsv && hits(addr)) || dma_hit) m_state = 0;
            else if (lr) m_tag = longint'(addr) >> G;
          end
          default: if (ack || err) m_state = 0;
        endcase
      end
    end
  end

  task automatic drive(bit r, bit w, bit s, logic [AW-1:0] a, bit dw, logic [AW-1:0] da,
                       bit c, bit k, bit e, logic [DW-1:0] d);
    re = r; we = w; rsv = s; addr = a; dma_we = dw; dma_addr = da;
    clear = c; ack = k; err = e; rdata = d;
    @(posedge clk); #1;
  endtask

  task automatic idle();                 drive(0,0,0,0,0,0,0,0,0,32'h0); endtask
  task automatic lr(logic [AW-1:0] a);   drive(1,0,1,a,0,0,0,0,0,32'h0); endtask
  task automatic sc(logic [AW-1:0] a);   drive(0,1,1,a,0,0,0,0,0,32'h0); endtask
  task automatic wr(logic [AW-1:0] a);   drive(0,1,0,a,0,0,0,0,0,32'h0); endtask
  task automatic bus_ok(logic [DW-1:0] d); drive(0,0,0,0,0,0,0,1,0,d); endtask

  initial begin
    re = 0; we = 0; rsv = 0; addr = 0; dma_we = 0; dma_addr = 0;
    clear = 0; ack = 0; err = 0; rdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tag = "R1"; idle(); sc(32'h100); idle(); idle();
    tag = "R3"; lr(32'h100); bus_ok(32'hDEAD_0001); idle();
    tag = "R2"; sc(32'h10C); tag = "R5"; bus_ok(32'h5555_AAAA); idle();
    tag = "R2"; lr(32'h104); bus_ok(32'h1); sc(32'h110); idle();
    tag = "R6"; sc(32'h104); idle();
    tag = "R4"; lr(32'h100); lr(32'h200); sc(32'h100); idle();
    lr(32'h100); lr(32'h200); sc(32'h208); bus_ok(32'h7); idle();
    tag = "R7"; lr(32'h300); wr(32'h400); bus_ok(32'h0); sc(32'h300); bus_ok(32'h0);
    lr(32'h300); wr(32'h30F); bus_ok(32'h0); sc(32'h300); idle();
    tag = "R8"; lr(32'h500); drive(0,0,0,0,1,32'h50C,0,0,0,0); sc(32'h500); idle();
    lr(32'h500); drive(0,0,0,0,1,32'h900,0,0,0,0); sc(32'h504); bus_ok(32'h3); idle();
    lr(32'h500); drive(0,1,1,32'h500,1,32'h508,0,0,0,0); idle();
    tag = "R9"; lr(32'h600); drive(0,0,0,0,0,0,1,0,0,0); sc(32'h600); idle();
    lr(32'h600); drive(0,1,1,32'h600,0,0,1,0,0,0); idle();
    drive(1,0,1,32'h600,0,0,1,0,0,0); sc(32'h600); idle();
    tag = "R10"; lr(32'h700); sc(32'h700);
    drive(0,0,0,0,0,0,1,0,0,0); sc(32'h700); idle();
    drive(0,0,0,0,0,0,0,0,1,32'hBAD); sc(32'h700); idle();
    tag = "R11"; drive(1,0,0,32'h40,0,0,0,0,0,0); bus_ok(32'h1234_5678);
    drive(0,0,0,0,0,0,0,0,1,32'h9); drive(0,0,0,0,0,0,0,1,1,32'hC0DE);
    idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule